// File: doc/BRIEF.md
# Multiplexed Address/Data Bus RAM Slave

This block lets an external processor reach a small on-chip memory through a 16-bit bus. The processor shares the same wires between address and data and runs from no clock that the chip knows. The processor first places an address on the bus and pulses an address strobe. It then uses active-low read and write strobes to move one data word. All four bus control lines are brought into the single system clock domain through two-flop synchronizers before anything uses them. A copy of the bus is delayed through an equal number of registers, so that data and strobes line up.

Inside the clock domain, the block finds the rising edge of the address strobe and latches the address from the delayed bus copy. It decodes a select from the upper ten address bits and indexes a 64-word by 16-bit synchronous RAM with the lower six. A write is committed once, on the synchronized falling edge of the write strobe. Read data is driven back onto the shared bus through a tri-state enable. No register in the block is clocked by a bus strobe. The master must hold the address, the data and every strobe stable for at least three system-clock periods.

Top module: `mux_bus_ram_slave`

## Requirements
- R1: While `rst` is high the bus output is high impedance. After reset the synchronizers are idle and the latched address is zero, so the block stays off the bus until a new address is latched. The RAM contents are not cleared.
- R2: On a synchronized rising edge of `addr_stb`, while synchronized `sel_n` is low, the block latches the 16-bit value on `ad_bus`.
- R3: A rising edge of `addr_stb` while `sel_n` is high leaves the latched address unchanged.
- R4: The block is selected only when bits [15:6] of the latched address equal the parameter `BASE`. An unselected address is neither written nor driven onto the bus.
- R5: Bits [5:0] of the latched address select one of the 64 RAM words. Different low bits reach distinct words.
- R6: A write happens once per low pulse of `wr_stb_n`, on its synchronized falling edge. It stores the bus value present at that edge. Bus changes while the strobe stays low do not write again.
- R7: While `rd_stb_n` is low and the block is selected, the block drives the addressed RAM word onto `ad_bus`. At all other times `ad_bus` is high impedance.
- R8: Strobes take effect only through the two-flop synchronizers. After `rd_stb_n` falls, the bus is still undriven after the next clock edge and is driven after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the RAM and all logic |
| rst | input | 1 | Synchronous active-high reset |
| addr_stb | input | 1 | Asynchronous address strobe, active high |
| sel_n | input | 1 | Asynchronous chip select, active low |
| rd_stb_n | input | 1 | Asynchronous read strobe, active low |
| wr_stb_n | input | 1 | Asynchronous write strobe, active low |
| ad_bus | inout | 16 | Shared address/data bus |

## Verification
The bench builds the block with `BASE` = 10'h2B7 instead of the default. This exercises a non-zero, irregular upper-bit match. It also keeps the post-reset address of zero outside the window, so reset can be seen at the bus. An unselected address, 16'h12D5, shares its low six bits with a selected one (16'hADD5). A stray write to it would therefore be visible as corruption of that word. The bus is pulled high, so an undriven bus reads back as 16'hFFFF, and no data word that the bench stores has that value.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BUS_W   = 16;
    localparam int RAM_AW  = 6;
    localparam int RAM_D   = 1 << RAM_AW;
    localparam int BASE_W  = BUS_W - RAM_AW;
    localparam int SYNC_N  = 2;

    typedef logic [BUS_W-1:0]  word_t;
    typedef logic [RAM_AW-1:0] ram_addr_t;
    typedef logic [BASE_W-1:0] base_t;

    // Bus control lines, raw or synchronized
    typedef struct packed {
        logic ale;
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    // RAM write request
    typedef struct packed {
        logic      en;
        ram_addr_t addr;
        word_t     data;
    } ram_wr_t;

    function automatic logic rose(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    function automatic logic fell(input logic now_v, input logic was_v);
        return ~now_v & was_v;
    endfunction

    function automatic base_t upper_of(input word_t a);
        return a[BUS_W-1:RAM_AW];
    endfunction

endpackage

// File: rtl/mbus_delay.sv
module mbus_delay #(
    parameter int              W      = 4,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_V;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_V;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
#(
    parameter base_t BASE = base_t'(10'h2C3)
) (
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctl_s,
    input  word_t   bus_s,
    output ram_wr_t wr_req,
    output ram_addr_t rd_addr,
    output logic    rd_drive
);
    ctrl_t ctl_prev;
    word_t addr_q;
    logic  ale_edge;
    logic  wr_edge;
    logic  hit;

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= CTRL_IDLE;
        else     ctl_prev <= ctl_s;
    end

    assign ale_edge = rose(ctl_s.ale, ctl_prev.ale);
    assign wr_edge  = fell(ctl_s.wr_n, ctl_prev.wr_n);

    always_ff @(posedge clk) begin
        if (rst)                         addr_q <= '0;
        else if (ale_edge && !ctl_s.cs_n) addr_q <= bus_s;
    end

    assign hit = (upper_of(addr_q) == BASE);

    always_comb begin
        wr_req.en   = wr_edge & hit;
        wr_req.addr = addr_q[RAM_AW-1:0];
        wr_req.data = bus_s;
    end

    assign rd_addr  = addr_q[RAM_AW-1:0];
    assign rd_drive = ~ctl_s.rd_n & hit;

    // R2, R3: latched address moves only after a selected strobe edge
    p_addr_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_q != $past(addr_q)) |-> $past(ale_edge && !ctl_s.cs_n))
        else $error("address changed without qualified strobe edge");

    // R2: strobe edge detector yields a single-cycle pulse
    p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        ale_edge |=> !ale_edge)
        else $error("address strobe edge lasted more than one cycle");

    // R6: a held write strobe never commits twice in a row
    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |=> !wr_req.en)
        else $error("back-to-back write commits");
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram
    import mbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ram_wr_t   wr_req,
    input  ram_addr_t rd_addr,
    output word_t     rd_data
);
    word_t mem [RAM_D];

    always_ff @(posedge clk) begin
        if (wr_req.en) mem[wr_req.addr] <= wr_req.data;
        rd_data <= mem[rd_addr];
    end

    // R5: a commit lands in the word its address names
    p_ram_store_r5: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |=> (mem[$past(wr_req.addr)] == $past(wr_req.data)))
        else $error("RAM word does not hold committed data");
endmodule

// File: rtl/mux_bus_ram_slave.sv
module mux_bus_ram_slave
    import mbus_pkg::*;
#(
    parameter base_t BASE = base_t'(10'h2C3)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_stb,
    input  logic        sel_n,
    input  logic        rd_stb_n,
    input  logic        wr_stb_n,
    inout  wire  [15:0] ad_bus
);
    ctrl_t     ctl_raw;
    ctrl_t     ctl_s;
    word_t     bus_s;
    ram_wr_t   wr_req;
    ram_addr_t rd_addr;
    word_t     rd_data;
    logic      rd_drive;
    logic      oe;

    always_comb begin
        ctl_raw.ale  = addr_stb;
        ctl_raw.cs_n = sel_n;
        ctl_raw.rd_n = rd_stb_n;
        ctl_raw.wr_n = wr_stb_n;
    end

    mbus_delay #(.W($bits(ctrl_t)), .STAGES(SYNC_N), .RST_V(CTRL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    // Bus copy delayed to match the strobe synchronizers
    mbus_delay #(.W(BUS_W), .STAGES(SYNC_N), .RST_V('0)) u_bus_dly (
        .clk(clk), .rst(rst), .d(ad_bus), .q(bus_s)
    );

    mbus_decode #(.BASE(BASE)) u_dec (
        .clk(clk), .rst(rst), .ctl_s(ctl_s), .bus_s(bus_s),
        .wr_req(wr_req), .rd_addr(rd_addr), .rd_drive(rd_drive)
    );

    mbus_ram u_ram (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign oe     = rd_drive & ~rst;
    assign ad_bus = oe ? rd_data : 'z;

    // R8: drive only once a low read strobe has crossed both sync stages
    p_drive_synced_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(!rd_stb_n, 2))
        else $error("bus driven before read strobe was synchronized");
endmodule

// File: tb/sim_mux_bus_ram_slave.sv
module sim_mux_bus_ram_slave;
    localparam logic [9:0]  BASE_T = 10'h2B7;
    localparam logic [15:0] FLOAT  = 16'hFFFF;
    localparam int NV = 8;
    // {address, data}
    localparam logic [31:0] VEC [NV] = '{
        {16'hADC0, 16'h1234}, {16'hADFF, 16'hBEEF}, {16'hADD5, 16'h0F0F},
        {16'hADEA, 16'h5A5A}, {16'hADC1, 16'h0001}, {16'hADFE, 16'h8000},
        {16'hADE0, 16'h7FFE}, {16'hADC7, 16'hC3C3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_stb = 1'b0, sel_n = 1'b1, rd_stb_n = 1'b1, wr_stb_n = 1'b1;
    logic [15:0] drv = '0;
    logic drv_en = 1'b0;
    tri1 [15:0] ad_bus;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    assign ad_bus = drv_en ? drv : 'z;
    always #5 clk = ~clk;

    mux_bus_ram_slave #(.BASE(BASE_T)) u0 (
        .clk(clk), .rst(rst), .addr_stb(addr_stb), .sel_n(sel_n),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .ad_bus(ad_bus)
    );

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_addr(input logic [15:0] a, input logic cs);
        @(negedge clk);
        drv = a; drv_en = 1'b1; sel_n = cs;
        wait_n(3); addr_stb = 1'b1;
        wait_n(4); addr_stb = 1'b0;
        wait_n(3); drv_en = 1'b0; sel_n = 1'b0;
    endtask

    task automatic put_data(input logic [15:0] d);
        @(negedge clk);
        drv = d; drv_en = 1'b1;
        wait_n(3); wr_stb_n = 1'b0;
        wait_n(4); wr_stb_n = 1'b1;
        wait_n(3); drv_en = 1'b0;
    endtask

    task automatic get_data(output logic [15:0] d);
        @(negedge clk);
        drv_en = 1'b0; rd_stb_n = 1'b0;
        wait_n(4); d = ad_bus;
        rd_stb_n = 1'b1;
        wait_n(4);
    endtask

    initial begin
        logic [15:0] r;
        wait_n(4);
        // R1: undriven during reset even with read strobe low
        rd_stb_n = 1'b0;
        wait_n(4);
        check(ad_bus === FLOAT, "R1 reset hi-z", ad_bus, FLOAT);
        rd_stb_n = 1'b1;
        rst = 1'b0;
        wait_n(3);

        // R2 R5 R6 R7: table of writes then reads
        for (int i = 0; i < NV; i++) begin
            put_addr(VEC[i][31:16], 1'b0);
            put_data(VEC[i][15:0]);
        end
        for (int i = 0; i < NV; i++) begin
            put_addr(VEC[i][31:16], 1'b0);
            get_data(r);
            check(r === VEC[i][15:0], "R2/R5/R7 readback", r, VEC[i][15:0]);
        end

        // R7: selected but read strobe high -> not driven
        put_addr(16'hADC0, 1'b0);
        wait_n(2);
        check(ad_bus === FLOAT, "R7 idle hi-z", ad_bus, FLOAT);

        // R3: strobe with chip select high is ignored
        put_addr(16'hADC0, 1'b0);
        put_addr(16'hADFF, 1'b1);
        get_data(r);
        check(r === 16'h1234, "R3 unselected strobe ignored", r, 16'h1234);

        // R4: unselected window, same low bits as ADD5
        put_addr(16'h12D5, 1'b0);
        put_data(16'hDEAD);
        get_data(r);
        check(r === FLOAT, "R4 no drive outside window", r, FLOAT);
        put_addr(16'hADD5, 1'b0);
        get_data(r);
        check(r === 16'h0F0F, "R4 no write outside window", r, 16'h0F0F);

        // R6: held strobe with changing bus writes only once
        put_addr(16'hADC7, 1'b0);
        @(negedge clk);
        drv = 16'h1111; drv_en = 1'b1;
        wait_n(3); wr_stb_n = 1'b0;
        wait_n(4); drv = 16'h2222;
        wait_n(6); wr_stb_n = 1'b1;
        wait_n(3); drv_en = 1'b0;
        get_data(r);
        check(r === 16'h1111, "R6 single commit on fall", r, 16'h1111);

        // R8: two-stage latency from read strobe to drive
        @(negedge clk); rd_stb_n = 1'b0;
        @(posedge clk); #1;
        check(ad_bus === FLOAT, "R8 undriven after one edge", ad_bus, FLOAT);
        @(posedge clk); #1;
        check(ad_bus === 16'h1111, "R8 driven after two edges", ad_bus, 16'h1111);

        // R1: reset while driving, then address cleared
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(ad_bus === FLOAT, "R1 reset releases bus", ad_bus, FLOAT);
        wait_n(2); rst = 1'b0;
        wait_n(5);
        check(ad_bus === FLOAT, "R1 address cleared after reset", ad_bus, FLOAT);
        rd_stb_n = 1'b1;
        wait_n(3);

        // R1: RAM content survives reset
        put_addr(16'hADEA, 1'b0);
        get_data(r);
        check(r === 16'h5A5A, "R1 RAM retained", r, 16'h5A5A);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule